// File: doc/BRIEF.md
# Reloading Tick Timer with Source Select

This block is a 16-bit up-counter held as two byte registers. Each tick adds one to the count. A tick taken while the count is all ones does not wrap to zero. It loads the count from a 16-bit reload pair, raises the high overflow flag and emits a one-cycle overflow pulse for downstream logic. A tick taken while the low byte is all ones also raises a low overflow flag, and this includes the full wrap. Both flags can be routed to one interrupt request.

The tick source is chosen by software. It can be every system clock cycle, or one of three other sources. The first is a free-running divide-by-12 prescaler of the system clock. The second is an asynchronous slow clock, synchronized and divided by eight. The third is an asynchronous comparator output, synchronized and edge detected. Counting happens only while the run bit is set. Software reaches the control register, the counter bytes and the reload bytes through a small byte-wide write/read port.

Top module: `reload_timer`

## Requirements
- R1: After reset every register reads zero, and both irq and ovf_pulse are low.
- R2: Register addresses are: 0 = control, 1 = count low byte, 2 = count high byte, 3 = reload low byte, 4 = reload high byte. Any other address reads zero. rdata follows addr combinationally. A write to a count byte replaces that byte, and any tick in the same cycle is discarded.
- R3: While control bit 0 (run) is 1, each tick adds one to the count. While run is 0 the count holds. A tick at count 0xFFFF loads the reload value as it stood before that edge, and ovf_pulse is high for exactly the following cycle.
- R4: A tick at count 0xFFFF sets control bit 7 (high flag). A tick with the low byte at 0xFF sets control bit 6 (low flag), and this includes the full wrap.
- R5: With control bit 1 set, every system clock cycle is a tick.
- R6: With bit 1 clear and bits 3:2 = 00, a tick occurs once every 12 system clocks. It comes from a prescaler that runs continuously from reset, and the first tick falls in the 12th cycle after reset.
- R7: With bits 3:2 = 01, the slow clock input passes through two synchronizing flops. Every eighth rising edge seen after synchronization is one tick.
- R8: With bits 3:2 = 11, each rising edge of the comparator input gives one tick after two synchronizing flops. With bits 3:2 = 10 there are no ticks.
- R9: irq = bit4 AND (bit7 OR (bit5 AND bit6)), where bit 4 is the interrupt enable and bit 5 is the low-overflow interrupt enable.
- R10: A control write loads all eight bits, so writing 0 clears a flag. A flag set by hardware in the same cycle as a clearing write stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| slow_clk | input | 1 | Asynchronous slow clock |
| cmp_in | input | 1 | Asynchronous comparator output |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | One-cycle 16-bit overflow pulse |

## Verification
Two events can fall in the same cycle: a hardware flag set and a software write of the control register that clears the flags. The bench provokes this by loading the count with 0xFFFF while the timer runs on the system clock, then writing zero flags on the very cycle that wraps the count. The flag must read back set.

A software write to a count byte can also coincide with a tick. The bench writes the low byte while ticking every cycle, and the tick must be lost. A behavioural model predicts both outcomes and is compared on every cycle.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
   typedef enum logic [2:0] {
      REG_CTRL   = 3'd0,
      REG_CNT_LO = 3'd1,
      REG_CNT_HI = 3'd2,
      REG_RLD_LO = 3'd3,
      REG_RLD_HI = 3'd4
   } reg_addr_e;

   typedef enum logic [1:0] {
      EXT_DIV12 = 2'b00,
      EXT_SLOW  = 2'b01,
      EXT_NONE  = 2'b10,
      EXT_CMP   = 2'b11
   } ext_sel_e;

   typedef struct packed {
      logic     hi_flag;
      logic     lo_flag;
      logic     lo_ie;
      logic     irq_en;
      ext_sel_e ext_sel;
      logic     sys_sel;
      logic     run;
   } ctrl_t;
endpackage

// File: rtl/rtmr_sync_edge.sv
module rtmr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rtmr_sync_edge: STAGES must be at least 2");
   end

   // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], async_in};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R8
endmodule

// File: rtl/rtmr_prescaler.sv
module rtmr_prescaler #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic pulse
);
   if (DIV < 1) begin : g_bad_div
      $error("rtmr_prescaler: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign pulse = en;
   end else begin : g_count
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;

      assign pulse = en && (cnt == CW'(DIV - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cnt <= '0;
         else if (en)  cnt <= pulse ? '0 : cnt + 1'b1;
      end

      AST_PULSE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
         pulse |=> !pulse); // R6
   end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
   import rtmr_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int PRE_DIV     = 12,
   parameter int SLOW_DIV    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_clk,
   input  logic              cmp_in,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              irq,
   output logic              ovf_pulse
);
   localparam int CNT_W = 2 * BYTE_W;

   if (BYTE_W < 8) begin : g_bad_width
      $error("reload_timer: BYTE_W must hold the 8-bit control register");
   end

   logic [CNT_W-1:0] cnt, rld;
   ctrl_t            ctrl;

   // ---------------- tick sources ----------------
   logic div12_tick, slow_rise, slow_tick, cmp_rise;

   rtmr_prescaler #(.DIV(PRE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .pulse(div12_tick));

   rtmr_sync_edge #(.STAGES(SYNC_STAGES)) u_slow_sync (
      .clk(clk), .rst_n(rst_n), .async_in(slow_clk), .rise(slow_rise));

   rtmr_prescaler #(.DIV(SLOW_DIV)) u_slow_div (
      .clk(clk), .rst_n(rst_n), .en(slow_rise), .pulse(slow_tick));

   rtmr_sync_edge #(.STAGES(SYNC_STAGES)) u_cmp_sync (
      .clk(clk), .rst_n(rst_n), .async_in(cmp_in), .rise(cmp_rise));

   logic ext_tick, tick;

   always_comb begin
      case (ctrl.ext_sel)
         EXT_DIV12: ext_tick = div12_tick;
         EXT_SLOW:  ext_tick = slow_tick;
         EXT_CMP:   ext_tick = cmp_rise;
         default:   ext_tick = 1'b0;
      endcase
   end

   assign tick = ctrl.run & (ctrl.sys_sel | ext_tick);

   // ---------------- register decode ----------------
   logic wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_rld_lo, wr_rld_hi, cnt_wr;
   assign wr_ctrl   = wr_en && (addr == REG_CTRL);
   assign wr_cnt_lo = wr_en && (addr == REG_CNT_LO);
   assign wr_cnt_hi = wr_en && (addr == REG_CNT_HI);
   assign wr_rld_lo = wr_en && (addr == REG_RLD_LO);
   assign wr_rld_hi = wr_en && (addr == REG_RLD_HI);
   assign cnt_wr    = wr_cnt_lo | wr_cnt_hi;

   // ---------------- counter ----------------
   logic adv, hi_set, lo_set;
   assign adv    = tick & ~cnt_wr;
   assign hi_set = adv & (&cnt);
   assign lo_set = adv & (&cnt[BYTE_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cnt_wr) begin
         if (wr_cnt_lo) cnt[BYTE_W-1:0]     <= wdata;
         if (wr_cnt_hi) cnt[CNT_W-1:BYTE_W] <= wdata;
      end else if (hi_set) begin
         cnt <= rld;
      end else if (adv) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld <= '0;
      end else begin
         if (wr_rld_lo) rld[BYTE_W-1:0]     <= wdata;
         if (wr_rld_hi) rld[CNT_W-1:BYTE_W] <= wdata;
      end
   end

   // ---------------- control and flags ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '0;
         ovf_pulse <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl <= ctrl_t'(wdata[7:0]);
         if (hi_set)  ctrl.hi_flag <= 1'b1;
         if (lo_set)  ctrl.lo_flag <= 1'b1;
         ovf_pulse <= hi_set;
      end
   end

   assign irq = ctrl.irq_en & (ctrl.hi_flag | (ctrl.lo_ie & ctrl.lo_flag));

   always_comb begin
      case (addr)
         REG_CTRL:   rdata = BYTE_W'(ctrl);
         REG_CNT_LO: rdata = cnt[BYTE_W-1:0];
         REG_CNT_HI: rdata = cnt[CNT_W-1:BYTE_W];
         REG_RLD_LO: rdata = rld[BYTE_W-1:0];
         REG_RLD_HI: rdata = rld[CNT_W-1:BYTE_W];
         default:    rdata = '0;
      endcase
   end

   // ---------------- assertions ----------------
   AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && (&cnt)) |=> (cnt == $past(rld))); // R3
   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.run && !cnt_wr) |=> $stable(cnt)); // R3
   AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> ctrl.hi_flag); // R4
   AST_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[7] && tick && !cnt_wr && (&cnt)) |=> ctrl.hi_flag); // R10
   AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt_lo |=> (cnt[BYTE_W-1:0] == $past(wdata))); // R2
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctrl.irq_en && (ctrl.hi_flag || ctrl.lo_flag))); // R9
endmodule

// File: tb/reload_timer_bench.sv
`timescale 1ns/1ps
module reload_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slow_clk = 1'b0;
   logic       cmp_in = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq, ovf_pulse;

   always #2.5 clk = ~clk;

   reload_timer u_reload_timer (
      .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .cmp_in(cmp_in),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .irq(irq), .ovf_pulse(ovf_pulse));

   int    n_chk = 0;
   int    n_fail = 0;
   string phase = "R1 reset";
   int    rot = 0;

   // ---------------- behavioural reference ----------------
   int       m_cnt, m_rld, m_pc, m_sc;
   bit       m_run, m_sys, m_ie, m_loie, m_hf, m_lf, m_ovf;
   int       m_ext;
   bit       cmp_q[$];
   bit       slow_q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_rld = 0; m_pc = 0; m_sc = 0; m_ext = 0;
         m_run = 0; m_sys = 0; m_ie = 0; m_loie = 0; m_hf = 0; m_lf = 0; m_ovf = 0;
         cmp_q = '{0, 0, 0};
         slow_q = '{0, 0, 0};
      end else begin
         bit cr, sr, st, tk, cw, adv, hs, ls;
         int old_rld;
         // queue index 1 = synchronized level, index 2 = its previous value
         cr = cmp_q[1] && !cmp_q[2];
         sr = slow_q[1] && !slow_q[2];
         case (m_ext)
            0:       st = (m_pc == 11);
            1:       st = sr && (m_sc == 7);
            3:       st = cr;
            default: st = 0;
         endcase
         tk  = m_run && (m_sys || st);
         cw  = wr_en && (addr == 3'd1 || addr == 3'd2);
         adv = tk && !cw;
         hs  = adv && (m_cnt == 16'hFFFF);
         ls  = adv && ((m_cnt % 256) == 255);
         old_rld = m_rld;
         if (wr_en && addr == 3'd0) begin
            m_run = wdata[0]; m_sys = wdata[1]; m_ext = int'(wdata[3:2]);
            m_ie = wdata[4]; m_loie = wdata[5]; m_lf = wdata[6]; m_hf = wdata[7];
         end
         if (wr_en && addr == 3'd3) m_rld = (m_rld / 256) * 256 + int'(wdata);
         if (wr_en && addr == 3'd4) m_rld = int'(wdata) * 256 + (m_rld % 256);
         if (cw) begin
            if (addr == 3'd1) m_cnt = (m_cnt / 256) * 256 + int'(wdata);
            else              m_cnt = int'(wdata) * 256 + (m_cnt % 256);
         end else if (hs) m_cnt = old_rld;
         else if (adv)    m_cnt = m_cnt + 1;
         if (hs) m_hf = 1;
         if (ls) m_lf = 1;
         m_ovf = hs;
         m_pc = (m_pc + 1) % 12;
         if (sr) m_sc = (m_sc + 1) % 8;
         cmp_q.push_front(cmp_in);   void'(cmp_q.pop_back());
         slow_q.push_front(slow_clk); void'(slow_q.pop_back());
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
      end
   endtask

   function automatic int exp_rd();
      case (addr)
         3'd0: return {m_hf, m_lf, m_loie, m_ie, 2'(m_ext), m_sys, m_run};
         3'd1: return m_cnt % 256;
         3'd2: return m_cnt / 256;
         3'd3: return m_rld % 256;
         3'd4: return m_rld / 256;
         default: return 0;
      endcase
   endfunction

   // compare at the falling edge, then drive the next inputs
   task automatic cyc(input bit we, input int a, input int d);
      @(negedge clk);
      chk("R2 rdata", int'(rdata), exp_rd());
      chk("R9 irq", int'(irq), int'(m_ie && (m_hf || (m_loie && m_lf))));
      chk("R3 ovf_pulse", int'(ovf_pulse), int'(m_ovf));
      wr_en = we; addr = 3'(a); wdata = 8'(d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         cyc(0, rot, 0);
         rot = (rot == 5) ? 0 : rot + 1;
      end
   endtask

   task automatic wr(input int a, input int d);
      cyc(1, a, d);
   endtask

   initial begin
      fork
         begin
            repeat (4) @(negedge clk);
            rst_n = 1'b1;
            phase = "R1 reset";
            idle(12);
            // fast source, wrap and reload
            phase = "R5 R3 R4 system clock wrap";
            wr(3, 8'h34); wr(4, 8'h12); wr(1, 8'hF0); wr(2, 8'hFF);
            wr(0, 8'h13);
            idle(40);
            // flag clear, then coincident clear and wrap
            phase = "R10 flag clear";
            wr(0, 8'h13);
            idle(6);
            phase = "R10 set wins over clear";
            wr(1, 8'hFF); wr(2, 8'hFF); wr(0, 8'h13);
            cyc(0, 0, 0);
            chk("R10 high flag after coincident clear", int'(rdata[7]), 1);
            idle(6);
            // low byte interrupt
            phase = "R4 R9 low byte wrap interrupt";
            wr(0, 8'h33); wr(1, 8'hF8); wr(2, 8'h00);
            idle(20);
            phase = "R9 low flag without low enable";
            wr(0, 8'h53);
            idle(5);
            // counter write collides with a tick
            phase = "R2 write beats tick";
            wr(0, 8'h03); wr(1, 8'h10);
            cyc(0, 1, 0);
            chk("R2 low byte after write", int'(rdata), 8'h10);
            idle(5);
            // stopped
            phase = "R3 stopped";
            wr(0, 8'h02);
            idle(20);
            // divide by 12
            phase = "R6 divide by twelve";
            wr(1, 8'h00); wr(2, 8'h00); wr(0, 8'h01);
            idle(80);
            // slow clock divided by 8
            phase = "R7 slow clock source";
            wr(0, 8'h05);
            for (int i = 0; i < 240; i++) begin
               idle(1);
               if (i % 3 == 0) slow_clk = ~slow_clk;
            end
            // comparator
            phase = "R8 comparator source";
            wr(0, 8'h0D);
            for (int i = 0; i < 120; i++) begin
               idle(1);
               if ((i % 7 == 0) || (i % 11 == 0)) cmp_in = ~cmp_in;
            end
            phase = "R8 unused selection";
            wr(0, 8'h09);
            for (int i = 0; i < 60; i++) begin
               idle(1);
               if (i % 4 == 0) cmp_in = ~cmp_in;
            end
            phase = "R2 unused address";
            cyc(0, 6, 0);
            cyc(0, 7, 0);
            idle(3);
         end
         begin
            repeat (150000) @(posedge clk);
            n_fail++;
            $display("FAIL watchdog expired in phase %s actual=hung expected=done", phase);
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule